// File: doc/BRIEF.md
# Pin Input Conditioning, Interrupt and Drive Control

This block handles one general-purpose pin. The pad input passes through two retiming stages in series; each stage is set on its own to pass the signal straight through, to capture it on the falling edge of the bus clock, or to capture it on the rising edge. The conditioned value feeds a trigger detector. The detector can fire on a rising edge, a falling edge, either edge, a low level or a high level, or it can be switched off. A detected event is held in a status bit. Two enable bits steer that status to a normal CPU interrupt line and to a non-maskable interrupt line, and either line can be used without the other.

On the output side the core's data and enable values reach the pad either as push-pull or as open-drain. In open-drain mode a logic high releases the pad. A wake-up request is formed without the clock from the raw pad level when a level trigger is selected. It is meant for waking the processor from light sleep. Software reaches the settings through a plain register port. The port writes on the rising edge and reads back at once.

Top module: `pin_cond_irq`

## Requirements
- R1: After reset the settings word (address 0) reads 0, the status bit reads 0, both interrupt outputs and the wake-up request are low, and the pad output follows the core in push-pull mode.
- R2: Each retiming stage has a 2-bit mode (stage A in settings bits 4:3, stage B in bits 6:5). The modes are 0 = pass-through, 1 = falling-edge capture and 2 or 3 = rising-edge capture. Stage B takes its input from stage A. With input driven just after a rising edge, status rises after 1 rising edge in modes 0/0, after 2 in modes 1/1, and after 3 in modes 2/2.
- R3: Trigger type (settings bits 2:0) 1 sets status on a 0-to-1 change of the conditioned input and not on a 1-to-0 change.
- R4: Trigger type 2 sets status on a 1-to-0 change and not on a 0-to-1 change.
- R5: Trigger type 3 sets status on a change in either direction.
- R6: In the edge types, status stays set until a write to address 1 with bit 0 high. A write with bit 0 low leaves it set.
- R7: Trigger types 4 (low) and 5 (high) make status follow the matching level one rising edge later. A clear write has no effect while the level is present.
- R8: Trigger type 0 (and the unused codes 6 and 7) keeps status at 0 whatever the input does, so neither interrupt asserts even with both enables set.
- R9: Settings bit 13 routes status to `irq_cpu` and bit 14 routes it to `irq_nmi`. The two bits act independently.
- R10: Settings bit 7 = 0 gives push-pull, with `pad_out` equal to `core_out` and `pad_oe` equal to `core_oe`. Bit 7 = 1 gives open-drain, where `pad_out` is 0 and `pad_oe` is `core_oe` AND NOT `core_out`.
- R11: `wake_req` is high only when settings bit 8 is set and the trigger type is 4 with the pad low or 5 with the pad high. It follows the pad without a clock edge.
- R12: Changing the trigger type while the input is held steady does not set status by itself.
- R13: Address 1 bit 1 reads back the conditioned input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 settings, 1 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pad_in | input | 1 | Raw pad input |
| core_out | input | 1 | Output value from the core |
| core_oe | input | 1 | Output enable from the core |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| irq_cpu | output | 1 | Normal CPU interrupt |
| irq_nmi | output | 1 | Non-maskable interrupt |
| wake_req | output | 1 | Light-sleep wake-up request |

## Verification
The assertions assume that `pad_in` and the register port change only between clock edges, so each capture flop sees a settled value on the edge it uses. They also assume that a settings write and a change of the pad never land in the same cycle, because the write cycle blanks edge detection. The stimulus drives every input one nanosecond after a rising edge, well before the falling edge. It changes the pad only after a write has completed and any stages that were just switched have settled.

// File: rtl/pin_cond_pkg.sv
// Shared settings layout and trigger codes for the pin conditioning block.
// Assumes a 32-bit register word; field positions are fixed here only.
package pin_cond_pkg;

    localparam int REG_W = 32;

    localparam logic [2:0] TRIG_OFF  = 3'd0;
    localparam logic [2:0] TRIG_RISE = 3'd1;
    localparam logic [2:0] TRIG_FALL = 3'd2;
    localparam logic [2:0] TRIG_ANY  = 3'd3;
    localparam logic [2:0] TRIG_LOW  = 3'd4;
    localparam logic [2:0] TRIG_HIGH = 3'd5;

    localparam int POS_TRIG  = 0;
    localparam int POS_STA   = 3;
    localparam int POS_STB   = 5;
    localparam int POS_OD    = 7;
    localparam int POS_WAKE  = 8;
    localparam int POS_CPU   = 13;
    localparam int POS_NMI   = 14;

    localparam int STAT_FLAG = 0;
    localparam int STAT_COND = 1;

    typedef struct packed {
        logic       nmi_en;
        logic       cpu_en;
        logic       wake_en;
        logic       open_drain;
        logic [1:0] stb_mode;
        logic [1:0] sta_mode;
        logic [2:0] trig;
    } pin_cfg_t;

    function automatic pin_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        pin_cfg_t c;
        c.trig       = w[POS_TRIG +: 3];
        c.sta_mode   = w[POS_STA +: 2];
        c.stb_mode   = w[POS_STB +: 2];
        c.open_drain = w[POS_OD];
        c.wake_en    = w[POS_WAKE];
        c.cpu_en     = w[POS_CPU];
        c.nmi_en     = w[POS_NMI];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input pin_cfg_t c);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[POS_TRIG +: 3]   = c.trig;
        w[POS_STA +: 2]    = c.sta_mode;
        w[POS_STB +: 2]    = c.stb_mode;
        w[POS_OD]          = c.open_drain;
        w[POS_WAKE]        = c.wake_en;
        w[POS_CPU]         = c.cpu_en;
        w[POS_NMI]         = c.nmi_en;
        return w;
    endfunction

    function automatic logic is_edge_trig(input logic [2:0] t);
        return (t == TRIG_RISE) || (t == TRIG_FALL) || (t == TRIG_ANY);
    endfunction

endpackage

// File: rtl/pin_cfg_regs.sv
// Settings register and read-back mux for one pin.
// Assumes a single-cycle write strobe; reads are combinational from reg_addr.
module pin_cfg_regs
    import pin_cond_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CFG_ADDR  = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              status,
    input  logic              cond_in,
    output pin_cfg_t          cfg,
    output logic              cfg_wr,
    output logic              stat_clr,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    // Decode the write strobes for the two registers.
    assign cfg_wr   = we && (addr == A_CFG);
    assign stat_clr = we && (addr == A_STAT) && wdata[STAT_FLAG];

    // Hold the settings word; reset to all fields zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg <= unpack_cfg(wdata);
        end
    end

    // Select read data by address.
    always_comb begin
        rdata = '0;
        if (addr == A_CFG) begin
            rdata = pack_cfg(cfg);
        end else if (addr == A_STAT) begin
            rdata[STAT_FLAG] = status;
            rdata[STAT_COND] = cond_in;
        end
    end

endmodule

// File: rtl/pin_sync_stage.sv
// One retiming stage: pass-through, falling-edge capture or rising-edge capture.
// Assumes din is stable around whichever clock edge the mode selects.
module pin_sync_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       din,
    output logic       dout
);

    logic q_rise;
    logic q_fall;

    // Capture on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q_rise <= 1'b0;
        else        q_rise <= din;
    end

    // Capture on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) q_fall <= 1'b0;
        else        q_fall <= din;
    end

    // Pick the stage output by mode.
    always_comb begin
        case (mode)
            2'd0:    dout = din;
            2'd1:    dout = q_fall;
            default: dout = q_rise;
        endcase
    end

    // R2: in a rising-capture mode the output is the input one edge earlier.
    a_r2_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |=> (!mode[1] || dout == $past(din)));

endmodule

// File: rtl/pin_trig_detect.sv
// Trigger detector and status bit for one pin.
// Assumes cfg_wr marks the cycle in which the trigger type may change; edges
// are not taken in that cycle, so a reconfiguration cannot create one.
module pin_trig_detect
    import pin_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] trig,
    input  logic       cond_in,
    input  logic       cfg_wr,
    input  logic       stat_clr,
    output logic       status
);

    logic prev_in;
    logic edge_hit;
    logic level_hit;

    // Keep the conditioned input from the previous rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= 1'b0;
        else        prev_in <= cond_in;
    end

    // Classify the current input against the selected trigger.
    always_comb begin
        edge_hit  = 1'b0;
        level_hit = 1'b0;
        case (trig)
            TRIG_RISE: edge_hit  = cond_in & ~prev_in;
            TRIG_FALL: edge_hit  = ~cond_in & prev_in;
            TRIG_ANY:  edge_hit  = cond_in ^ prev_in;
            TRIG_LOW:  level_hit = ~cond_in;
            TRIG_HIGH: level_hit = cond_in;
            default: begin
                edge_hit  = 1'b0;
                level_hit = 1'b0;
            end
        endcase
    end

    // Update status: sticky for edges, level-following for levels, zero when off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (trig == TRIG_LOW || trig == TRIG_HIGH) begin
            status <= level_hit;
        end else if (is_edge_trig(trig)) begin
            if (edge_hit && !cfg_wr) status <= 1'b1;
            else if (stat_clr)       status <= 1'b0;
        end else begin
            status <= 1'b0;
        end
    end

    // R6: an edge status holds until cleared or reconfigured.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_trig(trig) && status && !stat_clr && !cfg_wr) |=> status);

    // R7: a present high level shows in status on the next edge.
    a_r7_level_high: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_HIGH && cond_in) |=> status);

    // R8: the off setting never leaves status set.
    a_r8_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_OFF) |=> !status);

endmodule

// File: rtl/pin_pad_drive.sv
// Output driver mode: push-pull or open-drain.
// Assumes the pad resolves a released (disabled) driver to its pull-up.
module pin_pad_drive (
    input  logic open_drain,
    input  logic core_out,
    input  logic core_oe,
    output logic pad_out,
    output logic pad_oe
);

    // Map core data and enable onto the pad driver.
    always_comb begin
        if (open_drain) begin
            pad_out = 1'b0;
            pad_oe  = core_oe & ~core_out;
        end else begin
            pad_out = core_out;
            pad_oe  = core_oe;
        end
    end

endmodule

// File: rtl/pin_cond_irq.sv
// Top of the pin block: two retiming stages, trigger detector, interrupt
// routing, wake-up request and pad drive mode.
// Assumes all inputs change away from both clock edges.
module pin_cond_irq
    import pin_cond_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pad_in,
    input  logic              core_out,
    input  logic              core_oe,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              irq_cpu,
    output logic              irq_nmi,
    output logic              wake_req
);

    localparam int N_STAGE = 2;

    pin_cfg_t   cfg;
    logic       cfg_wr;
    logic       stat_clr;
    logic       status;
    logic [1:0] stage_mode [N_STAGE];
    logic [N_STAGE:0] chain;
    logic       cond_in;

    pin_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status   (status),
        .cond_in  (cond_in),
        .cfg      (cfg),
        .cfg_wr   (cfg_wr),
        .stat_clr (stat_clr),
        .rdata    (reg_rdata)
    );

    // Present the per-stage modes as an array for the chain.
    assign stage_mode[0] = cfg.sta_mode;
    assign stage_mode[1] = cfg.stb_mode;
    assign chain[0]      = pad_in;

    for (genvar gi = 0; gi < N_STAGE; gi++) begin : g_stage
        pin_sync_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (stage_mode[gi]),
            .din   (chain[gi]),
            .dout  (chain[gi+1])
        );
    end

    assign cond_in = chain[N_STAGE];

    pin_trig_detect u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (cfg.trig),
        .cond_in  (cond_in),
        .cfg_wr   (cfg_wr),
        .stat_clr (stat_clr),
        .status   (status)
    );

    pin_pad_drive u_drive (
        .open_drain (cfg.open_drain),
        .core_out   (core_out),
        .core_oe    (core_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    // Route status to each interrupt line through its own enable.
    assign irq_cpu = status & cfg.cpu_en;
    assign irq_nmi = status & cfg.nmi_en;

    // Clock-free wake-up from a present level on the raw pad.
    assign wake_req = cfg.wake_en &
                      (((cfg.trig == TRIG_LOW) & ~pad_in) |
                       ((cfg.trig == TRIG_HIGH) & pad_in));

    // R9: no interrupt without a pending status.
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        !status |-> (!irq_cpu && !irq_nmi));

    // R10: open-drain never drives a high level.
    a_r10_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.open_drain && pad_oe) |-> !pad_out);

    // R11: a wake request needs the wake enable and a level trigger.
    a_r11_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (cfg.wake_en && (cfg.trig == TRIG_LOW || cfg.trig == TRIG_HIGH)));

endmodule

// File: tb/sim_pin_cond_irq.sv
module sim_pin_cond_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pad_in = 1'b0;
    logic        core_out = 1'b0;
    logic        core_oe = 1'b0;
    logic        pad_out, pad_oe, irq_cpu, irq_nmi, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_cond_irq u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq_cpu(irq_cpu), .irq_nmi(irq_nmi),
        .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Settings word from fields.
    function automatic logic [31:0] cw(input int trig, input int sa, input int sb,
                                       input bit od, input bit wk, input bit cpu, input bit nmi);
        logic [31:0] w;
        w = '0;
        w[2:0] = trig[2:0]; w[4:3] = sa[1:0]; w[6:5] = sb[1:0];
        w[7] = od; w[8] = wk; w[13] = cpu; w[14] = nmi;
        return w;
    endfunction

    // Write on the next rising edge; returns 1 ns after it.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd1; reg_wdata = '0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic stat();
        return reg_rdata[0];
    endfunction

    task automatic t_reset();
        reg_addr = 2'd0; #1;
        chk("R1 settings", reg_rdata, 32'h0);
        reg_addr = 2'd1; #1;
        chk("R1 status", {31'b0, stat()}, 32'h0);
        chk("R1 irqs/wake", {29'b0, irq_cpu, irq_nmi, wake_req}, 32'h0);
        core_out = 1'b1; core_oe = 1'b1; #1;
        chk("R1 push-pull", {30'b0, pad_out, pad_oe}, 32'h3);
    endtask

    task automatic t_latency(input int m, input int lat);
        pad_in = 1'b0;
        wr(2'd0, cw(1, m, m, 0, 0, 0, 0));
        edges(4);
        wr(2'd1, 32'h1);
        pad_in = 1'b1;
        if (lat > 1) begin
            edges(lat - 1);
            chk($sformatf("R2 mode %0d early", m), {31'b0, stat()}, 32'h0);
            edges(1);
        end else begin
            edges(1);
        end
        chk($sformatf("R2 mode %0d latency", m), {31'b0, stat()}, 32'h1);
        chk("R13 cond readback", {31'b0, reg_rdata[1]}, 32'h1);
    endtask

    // One edge-type case: start level, toggle, expect status.
    task automatic t_edge(input string tag, input int trig, input bit from, input bit exp);
        pad_in = from;
        wr(2'd0, cw(trig, 0, 0, 0, 0, 0, 0));
        edges(2);
        wr(2'd1, 32'h1);
        pad_in = ~from;
        edges(2);
        chk(tag, {31'b0, stat()}, {31'b0, exp});
    endtask

    task automatic t_sticky();
        t_edge("R6 set", 1, 0, 1);
        pad_in = 1'b0;
        edges(3);
        chk("R6 held", {31'b0, stat()}, 32'h1);
        wr(2'd1, 32'h0);
        #1; chk("R6 zero write", {31'b0, stat()}, 32'h1);
        wr(2'd1, 32'h1);
        #1; chk("R6 cleared", {31'b0, stat()}, 32'h0);
    endtask

    task automatic t_level();
        pad_in = 1'b1;
        wr(2'd0, cw(5, 0, 0, 0, 0, 0, 0));
        edges(1);
        chk("R7 high set", {31'b0, stat()}, 32'h1);
        wr(2'd1, 32'h1);
        #1; chk("R7 clear ignored", {31'b0, stat()}, 32'h1);
        pad_in = 1'b0;
        edges(1);
        chk("R7 high gone", {31'b0, stat()}, 32'h0);
        wr(2'd0, cw(4, 0, 0, 0, 0, 0, 0));
        edges(1);
        chk("R7 low set", {31'b0, stat()}, 32'h1);
    endtask

    task automatic t_off();
        wr(2'd0, cw(0, 0, 0, 0, 0, 1, 1));
        for (int i = 0; i < 4; i++) begin
            pad_in = ~pad_in;
            edges(1);
            chk("R8 off status", {31'b0, stat()}, 32'h0);
        end
        chk("R8 off irqs", {30'b0, irq_cpu, irq_nmi}, 32'h0);
    endtask

    task automatic t_route();
        pad_in = 1'b1;
        wr(2'd0, cw(5, 0, 0, 0, 0, 1, 0));
        edges(1);
        chk("R9 cpu only", {30'b0, irq_cpu, irq_nmi}, 32'h2);
        wr(2'd0, cw(5, 0, 0, 0, 0, 0, 1));
        #1; chk("R9 nmi only", {30'b0, irq_cpu, irq_nmi}, 32'h1);
        wr(2'd0, cw(5, 0, 0, 0, 0, 1, 1));
        #1; chk("R9 both", {30'b0, irq_cpu, irq_nmi}, 32'h3);
    endtask

    task automatic t_drive();
        wr(2'd0, cw(0, 0, 0, 0, 0, 0, 0));
        core_out = 1'b0; core_oe = 1'b1; #1;
        chk("R10 pp low", {30'b0, pad_out, pad_oe}, 32'h1);
        wr(2'd0, cw(0, 0, 0, 1, 0, 0, 0));
        core_out = 1'b1; core_oe = 1'b1; #1;
        chk("R10 od high released", {30'b0, pad_out, pad_oe}, 32'h0);
        core_out = 1'b0; #1;
        chk("R10 od low driven", {30'b0, pad_out, pad_oe}, 32'h1);
        core_oe = 1'b0; #1;
        chk("R10 od disabled", {30'b0, pad_out, pad_oe}, 32'h0);
    endtask

    task automatic t_wake();
        pad_in = 1'b1;
        wr(2'd0, cw(4, 0, 0, 0, 1, 0, 0));
        #1; chk("R11 low absent", {31'b0, wake_req}, 32'h0);
        pad_in = 1'b0; #1;
        chk("R11 low present", {31'b0, wake_req}, 32'h1);
        wr(2'd0, cw(1, 0, 0, 0, 1, 0, 0));
        #1; chk("R11 edge type", {31'b0, wake_req}, 32'h0);
        wr(2'd0, cw(5, 0, 0, 0, 0, 0, 0));
        pad_in = 1'b1; #1;
        chk("R11 enable off", {31'b0, wake_req}, 32'h0);
    endtask

    task automatic t_retype();
        pad_in = 1'b1;
        wr(2'd0, cw(0, 0, 0, 0, 0, 0, 0));
        edges(2);
        wr(2'd0, cw(1, 0, 0, 0, 0, 0, 0));
        edges(3);
        chk("R12 no false edge", {31'b0, stat()}, 32'h0);
        wr(2'd0, cw(3, 2, 2, 0, 0, 0, 0));
        edges(4);
        chk("R12 any no false edge", {31'b0, stat()}, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_latency(0, 1);
        t_latency(1, 2);
        t_latency(2, 3);
        t_edge("R3 rise sets", 1, 0, 1);
        t_edge("R3 fall ignored", 1, 1, 0);
        t_edge("R4 fall sets", 2, 1, 1);
        t_edge("R4 rise ignored", 2, 0, 0);
        t_edge("R5 any rise", 3, 0, 1);
        t_edge("R5 any fall", 3, 1, 1);
        t_sticky();
        t_level();
        t_off();
        t_route();
        t_drive();
        t_wake();
        t_retype();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule